// File: doc/BRIEF.md
# NAND Flash Status Byte Generator

This block is the device-side logic that forms the byte a NAND flash device places on its 8-bit I/O bus in answer to a status-read command. It follows three pieces of state: whether the device is ready or busy, whether the most recent program or erase failed, and the level of the write-protect input. A controller-facing command path latches command bytes, and the block answers read-enable pulses with the status byte only while a status command is the most recently latched command.

Two status forms exist. The ordinary form (command 70h) gives one overall pass/fail bit. The multi-district form (command 71h) also gives one fail flag per district (plane) of a multi-block program or erase, for up to four districts. The flags come from an abstract program/erase engine, which reports the start of an operation, the completion of each page write with a fail flag per district, and the end of the operation. While an operation is running, only the readiness bit and the protect bit carry information. All pass/fail bits read as pass.

Top module: `nand_status_gen`

## Requirements
- R1: After synchronous reset the device is ready, all fail flags are clear, no status command is selected, and `dq_oe` and `dq_out` are 0.
- R2: Latching command 70h selects the ordinary status byte: bit 7 = `wp_n`, bit 6 = ready (1 ready, 0 busy), bit 0 = 1 if any district flag is set, and bits 1 to 5 = 0.
- R3: Latching command 71h selects the multi-district byte. It has the same bit 7, bit 6 and bit 0 as R2. Bit 1+d carries the fail flag of district d (d = 0..3), and bit 5 = 0.
- R4: `op_start` makes the device busy from the next cycle and clears every district fail flag. It takes precedence over `op_done` and `pg_done` in the same cycle.
- R5: `op_done` while busy, without `op_start`, makes the device ready from the next cycle.
- R6: Each `pg_done` while busy ORs `pg_fail` into the sticky district flags, so a district reads fail if any of its page writes in the operation failed. A `pg_done` while ready changes nothing.
- R7: While busy, the status byte shows bit 6 = 0 and bits 0 to 4 = 0 (pass), whatever flags are stored.
- R8: Bit 7 reports protection: 0 when `wp_n` is low (protected) and 1 when it is high.
- R9: The selected status form stays in effect across any number of read pulses until a new command is latched. Latching any byte other than 70h or 71h deselects status, and a read pulse then leaves `dq_oe` at 0.
- R10: A read pulse on `rd_en` in a status mode gives `dq_oe` = 1 and the byte on `dq_out` in the following cycle. In every other cycle both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Latched command value |
| rd_en | input | 1 | Read-enable pulse, one cycle per byte |
| wp_n | input | 1 | Write protect, low = protected |
| op_start | input | 1 | Engine starts a program or erase |
| op_done | input | 1 | Engine finished the operation |
| pg_done | input | 1 | One page write finished |
| pg_fail | input | 4 | Per-district fail of that page write |
| dq_out | output | 8 | Status byte to the I/O bus |
| dq_oe | output | 1 | Output drive enable for the I/O bus |

## Verification
The bench reads status while an operation is running with failures already stored. A design that does not mask would show fail bits during busy. It lets two page writes fail in different districts and checks that both flags remain set, which catches flags that are overwritten rather than accumulated. It also sends a page completion after ready, starts a new operation to confirm the flags clear, and sends a non-status command to confirm the output stops driving. A design that got these wrong would leak stale failures or keep driving the bus after another command.

// File: rtl/nand_status_pkg.sv
package nand_status_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_STD   = 2'd1,
    SEL_MULTI = 2'd2
  } stat_sel_e;

  localparam logic [7:0] CMD_STD   = 8'h70;
  localparam logic [7:0] CMD_MULTI = 8'h71;

  localparam int BIT_FAIL  = 0;
  localparam int BIT_DIST0 = 1;
  localparam int BIT_READY = 6;
  localparam int BIT_WPN   = 7;
endpackage

// File: rtl/nst_cmd_decode.sv
module nst_cmd_decode
  import nand_status_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  output stat_sel_e        sel
);
  stat_sel_e sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_NONE;
    end else if (cmd_valid) begin
      if (cmd_byte == CMD_W'(CMD_STD))
        sel_q <= SEL_STD;
      else if (cmd_byte == CMD_W'(CMD_MULTI))
        sel_q <= SEL_MULTI;
      else
        sel_q <= SEL_NONE;
    end
  end

  assign sel = sel_q;

  // R9: selection persists until a command is latched
  a_r9_sel_holds: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(sel_q));
  // R9: a non-status command deselects status output
  a_r9_other_deselects: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte != CMD_W'(CMD_STD) && cmd_byte != CMD_W'(CMD_MULTI))
      |=> sel_q == SEL_NONE);
endmodule

// File: rtl/nst_op_tracker.sv
module nst_op_tracker #(
  parameter int NDIST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_start,
  input  logic             op_done,
  input  logic             pg_done,
  input  logic [NDIST-1:0] pg_fail,
  output logic             busy,
  output logic [NDIST-1:0] fail_flags
);
  logic busy_q;
  logic [NDIST-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst)
      busy_q <= 1'b0;
    else if (op_start)
      busy_q <= 1'b1;
    else if (op_done)
      busy_q <= 1'b0;
  end

  for (genvar d = 0; d < NDIST; d++) begin : g_dist
    always_ff @(posedge clk) begin
      if (rst || op_start)
        flag_q[d] <= 1'b0;
      else if (busy_q && pg_done && pg_fail[d])
        flag_q[d] <= 1'b1;
    end
  end

  assign busy       = busy_q;
  assign fail_flags = flag_q;

  // R4: start makes busy and clears flags
  a_r4_start_clears: assert property (@(posedge clk) disable iff (rst)
    op_start |=> (busy_q && flag_q == '0));
  // R5: done returns to ready
  a_r5_done_ready: assert property (@(posedge clk) disable iff (rst)
    (op_done && !op_start) |=> !busy_q);
  // R6: nothing moves the flags while ready
  a_r6_idle_flags_stable: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !op_start) |=> $stable(flag_q));
  // R6: flags only accumulate during an operation
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !op_start) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/nst_byte_build.sv
module nst_byte_build
  import nand_status_pkg::*;
#(
  parameter int NDIST = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  stat_sel_e        sel,
  input  logic             busy,
  input  logic [NDIST-1:0] fail_flags,
  input  logic             wp_n,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  logic [DW-1:0] status_b;
  logic          any_fail;
  logic          show;

  assign any_fail = |fail_flags;
  assign show     = rd_en && (sel != SEL_NONE);

  always_comb begin
    status_b            = '0;
    status_b[BIT_WPN]   = wp_n;
    status_b[BIT_READY] = !busy;
    if (!busy) begin
      status_b[BIT_FAIL] = any_fail;
      if (sel == SEL_MULTI) begin
        for (int d = 0; d < NDIST; d++)
          status_b[BIT_DIST0 + d] = fail_flags[d];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      dq_oe  <= show;
      dq_out <= show ? status_b : '0;
    end
  end

  // R10: no drive without a status read
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    !show |=> (!dq_oe && dq_out == '0));
  // R7: busy masks pass/fail and ready bits
  a_r7_busy_mask: assert property (@(posedge clk) disable iff (rst)
    (show && busy) |=> (dq_out[4:0] == 5'd0 && !dq_out[BIT_READY]));
  // R8: protect bit follows write-protect input
  a_r8_wp_bit: assert property (@(posedge clk) disable iff (rst)
    show |=> dq_out[BIT_WPN] == $past(wp_n));
  // R2: ordinary status never shows district bits
  a_r2_std_no_dist: assert property (@(posedge clk) disable iff (rst)
    (show && sel == SEL_STD) |=> dq_out[5:1] == 5'd0);
endmodule

// File: rtl/nand_status_gen.sv
module nand_status_gen
  import nand_status_pkg::*;
#(
  parameter int NDIST = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [DW-1:0]    cmd_byte,
  input  logic             rd_en,
  input  logic             wp_n,
  input  logic             op_start,
  input  logic             op_done,
  input  logic             pg_done,
  input  logic [NDIST-1:0] pg_fail,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  stat_sel_e        sel;
  logic             busy;
  logic [NDIST-1:0] fail_flags;

  nst_cmd_decode #(.CMD_W(DW)) u_cmd (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .sel(sel)
  );

  nst_op_tracker #(.NDIST(NDIST)) u_trk (
    .clk(clk), .rst(rst), .op_start(op_start), .op_done(op_done),
    .pg_done(pg_done), .pg_fail(pg_fail), .busy(busy), .fail_flags(fail_flags)
  );

  nst_byte_build #(.NDIST(NDIST), .DW(DW)) u_byte (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .busy(busy),
    .fail_flags(fail_flags), .wp_n(wp_n), .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: tb/tb_nand_status_gen.sv
module tb_nand_status_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       rd_en = 1'b0;
  logic       wp_n = 1'b1;
  logic       op_start = 1'b0;
  logic       op_done = 1'b0;
  logic       pg_done = 1'b0;
  logic [3:0] pg_fail = 4'h0;
  logic [7:0] dq_out;
  logic       dq_oe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference state
  int       m_busy = 0;
  int       m_mode = 0;
  bit [3:0] m_flags = 0;
  bit [7:0] e_out = 0;
  bit       e_oe = 0;

  always #5 clk = ~clk;

  nand_status_gen dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .rd_en(rd_en), .wp_n(wp_n), .op_start(op_start), .op_done(op_done),
    .pg_done(pg_done), .pg_fail(pg_fail), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always @(posedge clk) begin
    bit [7:0] b;
    if (rst) begin
      m_busy = 0; m_mode = 0; m_flags = 0; e_out = 0; e_oe = 0;
    end else begin
      if (rd_en && m_mode != 0) begin
        b = 0;
        b[7] = wp_n;
        b[6] = (m_busy == 0);
        if (m_busy == 0) begin
          b[0] = (m_flags != 0);
          if (m_mode == 2) b[4:1] = m_flags;
        end
        e_oe = 1; e_out = b;
      end else begin
        e_oe = 0; e_out = 0;
      end
      if (cmd_valid) m_mode = (cmd_byte == 8'h70) ? 1 : (cmd_byte == 8'h71) ? 2 : 0;
      if (op_start) begin
        m_busy = 1; m_flags = 0;
      end else begin
        if (m_busy != 0 && pg_done) m_flags = m_flags | pg_fail;
        if (m_busy != 0 && op_done) m_busy = 0;
      end
    end
  end

  task automatic chk(input string req, input bit ok, input bit [8:0] act, input bit [8:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle, then compare outputs to the model away from the edge
  task automatic tick();
    @(negedge clk);
    chk({tag, " model"}, (dq_oe === e_oe) && (dq_out === e_out),
        {dq_oe, dq_out}, {e_oe, e_out});
  endtask

  task automatic send_cmd(input bit [7:0] c);
    cmd_valid = 1; cmd_byte = c; tick(); cmd_valid = 0;
  endtask

  task automatic read_expect(input string req, input bit oe, input bit [7:0] v);
    rd_en = 1; tick(); rd_en = 0;
    chk(req, (dq_oe === oe) && (dq_out === v), {dq_oe, dq_out}, {oe, v});
  endtask

  task automatic pulse_start();
    op_start = 1; tick(); op_start = 0;
  endtask

  task automatic pulse_done();
    op_done = 1; tick(); op_done = 0;
  endtask

  task automatic page(input bit [3:0] f);
    pg_done = 1; pg_fail = f; tick(); pg_done = 0; pg_fail = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1";
    tick();
    chk("R1 reset outputs", (dq_oe === 1'b0) && (dq_out === 8'h00), {dq_oe, dq_out}, 9'h000);
    read_expect("R1 no status selected", 0, 8'h00);

    tag = "R2";
    send_cmd(8'h70);
    read_expect("R2 ready pass", 1, 8'hC0);
    tag = "R8";
    wp_n = 0;
    read_expect("R8 protected", 1, 8'h40);
    wp_n = 1;

    tag = "R6";
    pulse_start();
    page(4'b0001);
    page(4'b1000);
    tag = "R7";
    read_expect("R7 busy masks fail", 1, 8'h80);
    send_cmd(8'h71);
    read_expect("R7 busy masks districts", 1, 8'h80);
    tag = "R5";
    pulse_done();
    read_expect("R6 sticky two districts", 1, 8'hD3);
    tag = "R9";
    read_expect("R9 repeated read", 1, 8'hD3);
    tick();
    read_expect("R9 third read", 1, 8'hD3);
    tag = "R2";
    send_cmd(8'h70);
    read_expect("R2 overall fail only", 1, 8'hC1);

    tag = "R4";
    pulse_start();
    pulse_done();
    read_expect("R4 flags cleared", 1, 8'hC0);

    tag = "R3";
    pulse_start();
    page(4'b0100);
    op_done = 1; pg_done = 1; pg_fail = 4'b0010; tick();
    op_done = 0; pg_done = 0; pg_fail = 0;
    send_cmd(8'h71);
    read_expect("R3 districts 1 and 2", 1, 8'hCD);
    tag = "R6";
    page(4'b1111);
    read_expect("R6 page while ready ignored", 1, 8'hCD);

    tag = "R4";
    op_start = 1; op_done = 1; pg_done = 1; pg_fail = 4'hF; tick();
    op_start = 0; op_done = 0; pg_done = 0; pg_fail = 0;
    read_expect("R4 start wins", 1, 8'h80);
    pulse_done();
    read_expect("R5 ready again", 1, 8'hC0);

    tag = "R9";
    send_cmd(8'h00);
    read_expect("R9 other command deselects", 0, 8'h00);
    tag = "R10";
    rd_en = 0;
    repeat (3) tick();
    chk("R10 idle no drive", (dq_oe === 1'b0) && (dq_out === 8'h00), {dq_oe, dq_out}, 9'h000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule